// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches four asynchronous modem handshake inputs: carrier detect, ring indicator, data-set-ready and clear-to-send. Each line is brought into the clock domain through a multi-flop synchronizer. The block reports the current synchronized level of each line and keeps a sticky change flag per line. It gathers everything into one 9-bit status word that a register bank can read.

Three of the flags record a change in either direction. The ring flag records only the moment the ring line drops back to inactive. Software clears any flag by writing 1 to its position in the status word. Whenever a flag goes from clear to set, the block emits a one-cycle event pulse toward an interrupt register bank.

The same block holds the two modem output lines and an automatic-flow-control select bit, all loaded by a control write. It also stores a flow-control mode bit that is readable and writable through the status word. That bit is passed through and not acted on here.

Top module: `modem_status_detect`

## Requirements
- R1: After reset, the status word, `delta_irq`, `dtr_out`, `rts_out` and `autoflow_out` are all 0.
- R2: Status bits 7, 6, 5 and 4 show the synchronized levels of carrier detect, ring, data-set-ready and clear-to-send. A level driven before a clock edge appears after the second edge (two synchronizer flops).
- R3: A change in either direction of clear-to-send, data-set-ready or carrier detect sets status bit 0, 1 or 3 respectively. The bit is set on the clock edge after the new level appears in the status word.
- R4: Status bit 2 is set only when the synchronized ring level goes from 1 to 0, with the same timing as R3. A 0-to-1 ring transition leaves bit 2 unchanged.
- R5: Status bits 3 to 0 stay set until a status write (`stat_wr` high) carries a 1 in that bit position. Writing 0 to a bit leaves it unchanged.
- R6: When a write-1 clear and a new change on the same line arrive on the same clock edge, the flag stays set.
- R7: `delta_irq` is high for exactly the cycle after an edge on which at least one of status bits 3 to 0 went from 0 to 1. A change on a line whose flag is already set raises no pulse.
- R8: A control write (`ctrl_wr` high) loads `dtr_out` from data bit 0, `rts_out` from bit 1 and `autoflow_out` from bit 5. The outputs change on that write's clock edge.
- R9: Status bit 8 is a flow-control mode bit that a status write loads from data bit 8. It reads back unchanged until the next status write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dcd_in | input | 1 | Asynchronous carrier-detect line |
| ri_in | input | 1 | Asynchronous ring-indicator line |
| dsr_in | input | 1 | Asynchronous data-set-ready line |
| cts_in | input | 1 | Asynchronous clear-to-send line |
| stat_wr | input | 1 | Status word write strobe |
| stat_wdata | input | 9 | Status write data: bits 3..0 write-1-clear, bit 8 mode |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 6 | Control write data: bit 0 DTR, bit 1 RTS, bit 5 auto flow |
| stat_word | output | 9 | Mode, line levels and sticky change flags |
| dtr_out | output | 1 | Data-terminal-ready output |
| rts_out | output | 1 | Request-to-send output |
| autoflow_out | output | 1 | Automatic flow control select |
| delta_irq | output | 1 | One-cycle change event pulse |

## Verification
The assertions check several rules on every cycle:
- a flag survives any cycle without a matching clear;
- a change on an any-edge line always sets its flag;
- a rising ring level never sets the ring flag;
- every event pulse coincides with a newly set flag;
- control outputs follow the write data.

Only the bench scenarios can show the exact synchronizer latency and the order of level and flag updates. The same holds for a clear that collides with a new change, for the absence of a pulse on an already-set flag, and for the mode bit read-back. The bench covers these both in directed sequences and under random line activity mixed with random writes.

// File: rtl/msd_pkg.sv
package msd_pkg;
    localparam int LINES   = 4;
    localparam int L_CTS   = 0;
    localparam int L_DSR   = 1;
    localparam int L_RI    = 2;
    localparam int L_DCD   = 3;
    localparam int STAT_W  = 9;
    localparam int CTRL_W  = 6;
    localparam int MODE_BIT = 8;
    localparam int C_DTR   = 0;
    localparam int C_RTS   = 1;
    localparam int C_AUTO  = 5;

    typedef enum logic {EDGE_ANY, EDGE_FALL} edge_kind_e;

    function automatic edge_kind_e kind_of(int idx);
        return (idx == L_RI) ? EDGE_FALL : EDGE_ANY;
    endfunction
endpackage

// File: rtl/msd_sync.sv
module msd_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = async_in;
        for (int k = 1; k < STAGES; k++) begin
            st_d.pipe[k] = st_q.pipe[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.pipe[STAGES-1];
endmodule

// File: rtl/msd_delta.sv
module msd_delta
    import msd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lvl,
    input  logic [LINES-1:0] clr,
    output logic [LINES-1:0] delta,
    output logic             irq
);
    typedef struct packed {
        logic [LINES-1:0] prev;
        logic [LINES-1:0] delta;
        logic             irq;
    } delta_st_t;

    delta_st_t st_d, st_q;
    logic [LINES-1:0] ev;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        if (kind_of(i) == EDGE_FALL) begin : g_fall
            assign ev[i] = st_q.prev[i] & ~lvl[i];
            // R4: a rising ring level never sets its flag
            a_r4_rise_no_set: assert property (@(posedge clk) disable iff (!rst_n)
                ($rose(lvl[i]) && !st_q.delta[i]) |=> !st_q.delta[i]);
        end else begin : g_any
            assign ev[i] = st_q.prev[i] ^ lvl[i];
            // R3: any level change sets the flag on the next edge
            a_r3_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
                (lvl[i] != st_q.prev[i]) |=> st_q.delta[i]);
        end
        // R5: a set flag survives a cycle without a clear for it
        a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.delta[i] && !clr[i]) |=> st_q.delta[i]);
    end

    always_comb begin
        st_d       = st_q;
        st_d.prev  = lvl;
        st_d.delta = (st_q.delta & ~clr) | ev;
        st_d.irq   = |(st_d.delta & ~st_q.delta);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign delta = st_q.delta;
    assign irq   = st_q.irq;
endmodule

// File: rtl/msd_ctrl.sv
module msd_ctrl
    import msd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              mode_wr,
    input  logic              mode_wdata,
    output logic              dtr,
    output logic              rts,
    output logic              autoflow,
    output logic              mode
);
    typedef struct packed {
        logic dtr;
        logic rts;
        logic autoflow;
        logic mode;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic unused_ctrl_bits;

    assign unused_ctrl_bits = ^ctrl_wdata[4:2];

    always_comb begin
        st_d = st_q;
        if (ctrl_wr) begin
            st_d.dtr      = ctrl_wdata[C_DTR];
            st_d.rts      = ctrl_wdata[C_RTS];
            st_d.autoflow = ctrl_wdata[C_AUTO];
        end
        if (mode_wr) st_d.mode = mode_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dtr      = st_q.dtr;
    assign rts      = st_q.rts;
    assign autoflow = st_q.autoflow;
    assign mode     = st_q.mode;

    // R8: control outputs follow the written data bits
    a_r8_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (dtr == $past(ctrl_wdata[C_DTR]) && rts == $past(ctrl_wdata[C_RTS])
                     && autoflow == $past(ctrl_wdata[C_AUTO])));
    // R9: mode bit holds without a write
    a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr |=> $stable(mode));
endmodule

// File: rtl/modem_status_detect.sv
module modem_status_detect
    import msd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dcd_in,
    input  logic              ri_in,
    input  logic              dsr_in,
    input  logic              cts_in,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [STAT_W-1:0] stat_word,
    output logic              dtr_out,
    output logic              rts_out,
    output logic              autoflow_out,
    output logic              delta_irq
);
    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] clr_mask;
    logic [LINES-1:0] delta;
    logic             mode;
    logic             unused_stat_bits;

    always_comb begin
        raw_lines        = '0;
        raw_lines[L_CTS] = cts_in;
        raw_lines[L_DSR] = dsr_in;
        raw_lines[L_RI]  = ri_in;
        raw_lines[L_DCD] = dcd_in;
    end

    assign clr_mask         = stat_wr ? stat_wdata[LINES-1:0] : '0;
    assign unused_stat_bits = ^stat_wdata[MODE_BIT-1:2*LINES-4];

    msd_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_lines),
        .sync_out (lvl)
    );

    msd_delta delta_i (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl),
        .clr   (clr_mask),
        .delta (delta),
        .irq   (delta_irq)
    );

    msd_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .mode_wr    (stat_wr),
        .mode_wdata (stat_wdata[MODE_BIT]),
        .dtr        (dtr_out),
        .rts        (rts_out),
        .autoflow   (autoflow_out),
        .mode       (mode)
    );

    assign stat_word = {mode, lvl, delta};

    // R7: every event pulse comes with a flag that was clear a cycle before
    a_r7_irq_new_flag: assert property (@(posedge clk) disable iff (!rst_n)
        delta_irq |-> |(delta & ~$past(delta)));
endmodule

// File: tb/modem_status_detect_tb_top.sv
module modem_status_detect_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dcd_in = 1'b0, ri_in = 1'b0, dsr_in = 1'b0, cts_in = 1'b0;
    logic       stat_wr = 1'b0;
    logic [8:0] stat_wdata = '0;
    logic       ctrl_wr = 1'b0;
    logic [5:0] ctrl_wdata = '0;
    logic [8:0] stat_word;
    logic       dtr_out, rts_out, autoflow_out, delta_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // expected state after the most recent edge
    logic [3:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_delta = '0;
    logic       m_irq = 1'b0, m_mode = 1'b0, m_dtr = 1'b0, m_rts = 1'b0, m_af = 1'b0;

    always #4 clk = ~clk;

    modem_status_detect dut_i (
        .clk(clk), .rst_n(rst_n),
        .dcd_in(dcd_in), .ri_in(ri_in), .dsr_in(dsr_in), .cts_in(cts_in),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .stat_word(stat_word), .dtr_out(dtr_out), .rts_out(rts_out),
        .autoflow_out(autoflow_out), .delta_irq(delta_irq)
    );

    function automatic logic [3:0] line_events(logic [3:0] lv, logic [3:0] pv);
        // bit order: 0 CTS, 1 DSR, 2 RI, 3 DCD; RI only on falling
        return ((lv ^ pv) & 4'b1011) | (pv & ~lv & 4'b0100);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycle(logic [3:0] lines, logic swr, logic [8:0] swd,
                         logic cwr, logic [5:0] cwd);
        logic [3:0] nd;
        {dcd_in, ri_in, dsr_in, cts_in} = lines;
        stat_wr = swr; stat_wdata = swd; ctrl_wr = cwr; ctrl_wdata = cwd;
        nd = (m_delta & ~(swr ? swd[3:0] : 4'b0)) | line_events(m_s2, m_prev);
        m_irq   = |(nd & ~m_delta);
        m_delta = nd;
        m_prev  = m_s2;
        m_s2    = m_s1;
        m_s1    = lines;
        if (swr) m_mode = swd[8];
        if (cwr) begin m_dtr = cwd[0]; m_rts = cwd[1]; m_af = cwd[5]; end
        @(posedge clk);
        @(negedge clk);
        stat_wr = 1'b0; ctrl_wr = 1'b0;
    endtask

    task automatic cmp_model(string tag);
        chk(tag, {23'd0, stat_word}, {23'd0, m_mode, m_s2, m_delta});
        chk(tag, {28'd0, delta_irq, dtr_out, rts_out, autoflow_out},
                 {28'd0, m_irq, m_dtr, m_rts, m_af});
    endtask

    task automatic idle(logic [3:0] lines, int n);
        for (int k = 0; k < n; k++) cycle(lines, 1'b0, 9'h0, 1'b0, 6'h0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", {23'd0, stat_word}, 32'h0);
        chk("R1 outputs", {28'd0, delta_irq, dtr_out, rts_out, autoflow_out}, 32'h0);

        // CTS rise: level after two edges, flag one edge later
        cycle(4'b0001, 0, 0, 0, 0);
        chk("R2 cts not yet", {31'd0, stat_word[4]}, 32'h0);
        cycle(4'b0001, 0, 0, 0, 0);
        chk("R2 cts level", {30'd0, stat_word[4], stat_word[0]}, 32'h2);
        cycle(4'b0001, 0, 0, 0, 0);
        chk("R3 cts rise flag", {31'd0, stat_word[0]}, 32'h1);
        chk("R7 pulse", {31'd0, delta_irq}, 32'h1);
        idle(4'b0001, 1);
        chk("R7 pulse one cycle", {31'd0, delta_irq}, 32'h0);
        cmp_model("R5 model");

        // write 0 leaves it, write 1 clears it
        cycle(4'b0001, 1, 9'h000, 0, 0);
        chk("R5 write zero keeps", {31'd0, stat_word[0]}, 32'h1);
        cycle(4'b0001, 1, 9'h001, 0, 0);
        chk("R5 write one clears", {31'd0, stat_word[0]}, 32'h0);

        // CTS fall sets flag again
        idle(4'b0000, 3);
        chk("R3 cts fall flag", {31'd0, stat_word[0]}, 32'h1);
        cycle(4'b0000, 1, 9'h00F, 0, 0);

        // RI rising: no flag; falling: flag
        idle(4'b0100, 4);
        chk("R4 ri rise level", {31'd0, stat_word[6]}, 32'h1);
        chk("R4 ri rise no flag", {31'd0, stat_word[2]}, 32'h0);
        chk("R4 ri rise no pulse", {31'd0, delta_irq}, 32'h0);
        idle(4'b0000, 3);
        chk("R4 ri fall flag", {31'd0, stat_word[2]}, 32'h1);
        cycle(4'b0000, 1, 9'h00F, 0, 0);

        // DCD and DSR rising together
        idle(4'b1010, 3);
        chk("R3 dcd dsr flags", {28'd0, stat_word[3:0]}, 32'hA);
        idle(4'b1010, 1);
        // DSR falls while its flag is still set: no new pulse
        idle(4'b1000, 3);
        chk("R7 no pulse when set", {31'd0, delta_irq}, 32'h0);
        chk("R5 dsr still set", {31'd0, stat_word[1]}, 32'h1);

        // clear colliding with a new DSR change
        cycle(4'b1000, 1, 9'h00F, 0, 0);
        chk("R5 cleared", {28'd0, stat_word[3:0]}, 32'h0);
        cycle(4'b1010, 0, 0, 0, 0);
        cycle(4'b1010, 0, 0, 0, 0);
        cycle(4'b1010, 1, 9'h002, 0, 0);
        chk("R6 clear vs change", {31'd0, stat_word[1]}, 32'h1);
        cmp_model("R6 model");

        // control outputs
        cycle(4'b1010, 0, 0, 1, 6'b100011);
        chk("R8 ctrl set", {29'd0, dtr_out, rts_out, autoflow_out}, 32'h7);
        cycle(4'b1010, 0, 0, 1, 6'b011110);
        chk("R8 ctrl mix", {29'd0, dtr_out, rts_out, autoflow_out}, 32'h2);

        // mode bit read/write
        cycle(4'b1010, 1, 9'h100, 0, 0);
        chk("R9 mode set", {31'd0, stat_word[8]}, 32'h1);
        idle(4'b1010, 2);
        chk("R9 mode hold", {31'd0, stat_word[8]}, 32'h1);
        cycle(4'b1010, 1, 9'h000, 0, 0);
        chk("R9 mode clear", {31'd0, stat_word[8]}, 32'h0);

        // random activity against the model
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] ln;
            logic       sw, cw;
            logic [8:0] sd;
            logic [5:0] cd;
            ln = ($urandom % 4 == 0) ? 4'($urandom) : {dcd_in, ri_in, dsr_in, cts_in};
            sw = ($urandom % 4 == 0);
            sd = 9'($urandom);
            cw = ($urandom % 8 == 0);
            cd = 6'($urandom);
            cycle(ln, sw, sd, cw, cd);
            cmp_model("R2 R3 R4 R5 R6 R7 R8 R9 random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule